// File: doc/BRIEF.md
# Reference Clock Activity Monitor

This block watches several reference clock inputs at once and reports, for each one, whether it is still toggling. Every input is brought into a single monitor clock domain through its own synchronizer, and the monitor looks for level changes there. For each input, a window counter measures how long it has been since the last change. The counter is sized to one period of the feedback clock, given in monitor-clock cycles. If an input stays at one level for longer than that window, its loss flag goes high. The flag drops again as soon as the input is seen toggling.

The flags report live health and do not latch. Downstream switching logic can read them at any time, whichever input it is using as the reference at that moment. All inputs are watched all the time, and no input's flag depends on another input. After reset every flag reads "lost" until activity has actually been observed on that input.

Top module: `refmon_top`

## Requirements
- R1: While reset is asserted, and after it is released, every bit of `ref_lost` is 1 until a level change has been seen on the matching input.
- R2: Each input has its own flag. Toggling or stopping one input never changes the flag of another input.
- R3: If an input changes level just before monitor edge N and then stays high, its flag is 0 after edge N+1+WIN_CYCLES and 1 after edge N+2+WIN_CYCLES.
- R4: The same timing as R3 applies when an input stays low.
- R5: An input whose successive level changes are at most WIN_CYCLES monitor cycles apart is never flagged.
- R6: A flagged input whose level changes just before monitor edge N reads 0 after edge N+2. This covers a two-flop synchronizer plus one registered edge-detect stage.
- R7: All inputs are monitored at the same time and without pause. Any mix of active and stalled inputs is reported correctly on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | NUM_REFS | Reference clock inputs, asynchronous to `clk` |
| ref_lost | output | NUM_REFS | Per-input loss flag, 1 = not toggling |

## Verification
The hardest case to reach is an input whose gaps between changes sit exactly on the window boundary. Gaps of WIN_CYCLES must never raise the flag, while a gap of WIN_CYCLES+1 must raise it for exactly one cycle before the next change clears it. The stimulus drives each input from a per-cycle pattern generator with a programmable toggle interval. Runs at interval WIN_CYCLES and then WIN_CYCLES+1 place the counter's expiry cycle directly on top of an arriving edge. Other runs pair a fast input with a stalled one to expose any cross-talk between the channels.

// File: rtl/refmon_pkg.sv
package refmon_pkg;

    localparam int unsigned DEF_NUM_REFS    = 2;
    localparam int unsigned DEF_WIN_CYCLES  = 8;
    localparam int unsigned DEF_SYNC_STAGES = 2;

    // Counter width able to hold the saturated value win.
    function automatic int unsigned win_cnt_w(input int unsigned win);
        return (win < 2) ? 1 : $clog2(win + 1);
    endfunction

endpackage

// File: rtl/refmon_sync.sv
module refmon_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    localparam int unsigned LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.chain[LAST];

    generate
        if (STAGES > 1) begin : g_chk
            // R6
            sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q.chain[LAST-1] == st_q.chain[LAST]) |=> $stable(sync_out));
        end
    endgenerate

endmodule

// File: rtl/refmon_chan.sv
module refmon_chan #(
    parameter int unsigned WIN_CYCLES = refmon_pkg::DEF_WIN_CYCLES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic lost
);
    localparam int unsigned CW = refmon_pkg::win_cnt_w(WIN_CYCLES);
    localparam logic [CW-1:0] CNT_SAT  = CW'(WIN_CYCLES);
    localparam logic [CW-1:0] CNT_LAST = CW'(WIN_CYCLES - 1);

    typedef struct packed {
        logic          prev;
        logic [CW-1:0] cnt;
        logic          lost;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     seen_edge;

    assign seen_edge = lvl ^ st_q.prev;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl;
        if (seen_edge) begin
            st_d.cnt  = '0;
            st_d.lost = 1'b0;
        end else if (st_q.cnt != CNT_SAT) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == CNT_LAST) st_d.lost = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev <= 1'b0;
            st_q.cnt  <= CNT_SAT;
            st_q.lost <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign lost = st_q.lost;

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_SAT);

    // R3
    flag_rise_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lost) |-> $past(!seen_edge));

    // R6
    flag_fall_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lost) |-> $past(seen_edge));

    // R6
    edge_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_edge |=> !lost);

endmodule

// File: rtl/refmon_top.sv
module refmon_top #(
    parameter int unsigned NUM_REFS    = refmon_pkg::DEF_NUM_REFS,
    parameter int unsigned WIN_CYCLES  = refmon_pkg::DEF_WIN_CYCLES,
    parameter int unsigned SYNC_STAGES = refmon_pkg::DEF_SYNC_STAGES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_REFS-1:0] ref_in,
    output logic [NUM_REFS-1:0] ref_lost
);
    logic [NUM_REFS-1:0] ref_sync;

    generate
        for (genvar g = 0; g < NUM_REFS; g++) begin : g_ref
            refmon_sync #(.STAGES(SYNC_STAGES)) sync_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .async_in (ref_in[g]),
                .sync_out (ref_sync[g])
            );
            refmon_chan #(.WIN_CYCLES(WIN_CYCLES)) chan_i (
                .clk   (clk),
                .rst_n (rst_n),
                .lvl   (ref_sync[g]),
                .lost  (ref_lost[g])
            );
        end
    endgenerate

    // R1
    reset_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ref_lost == '1));

endmodule

// File: tb/refmon_top_tb_top.sv
`timescale 1ns/1ps
module refmon_top_tb_top;
    localparam int NREF = 2;
    localparam int WIN  = 8;

    typedef struct {
        int             cyc;
        logic [NREF-1:0] exp;
        string          req;
    } exp_item_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NREF-1:0] ref_in = '0;
    logic [NREF-1:0] ref_lost;

    int        cyc = 0;
    int        n_chk = 0;
    int        n_fail = 0;
    exp_item_t sb_q[$];
    string     cur_req = "R1";
    int        last_chg[NREF];
    bit        seen[NREF];

    refmon_top #(.NUM_REFS(NREF), .WIN_CYCLES(WIN), .SYNC_STAGES(2)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_in   (ref_in),
        .ref_lost (ref_lost)
    );

    always #2 clk = ~clk;

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    task automatic check(input string req, input int ch, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s cyc=%0d ch=%0d actual=%b expected=%b", req, cyc, ch, act, exp);
        end
    endtask

    // Driver: apply new levels at cycle M, predict flags for cycle M+3.
    task automatic step(input logic [NREF-1:0] lv);
        exp_item_t it;
        @(negedge clk);
        for (int i = 0; i < NREF; i++) begin
            if (lv[i] !== ref_in[i]) begin
                seen[i] = 1'b1;
                last_chg[i] = cyc;
            end
        end
        ref_in = lv;
        it.cyc = cyc + 3;
        it.req = cur_req;
        for (int i = 0; i < NREF; i++)
            it.exp[i] = !seen[i] || ((cyc - last_chg[i]) >= WIN);
        sb_q.push_back(it);
    endtask

    // Toggle channel i every p[i] steps (0 = hold), n steps.
    task automatic run(input int p0, input int p1, input int n);
        logic [NREF-1:0] lv;
        for (int k = 0; k < n; k++) begin
            lv = ref_in;
            if (p0 > 0 && (k % p0) == 0) lv[0] = ~lv[0];
            if (p1 > 0 && (k % p1) == 0) lv[1] = ~lv[1];
            step(lv);
        end
    endtask

    task automatic set_lvl(input int ch, input logic v);
        logic [NREF-1:0] lv;
        lv = ref_in;
        lv[ch] = v;
        step(lv);
    endtask

    // Monitor: pop and compare as cycles arrive.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
                exp_item_t it;
                it = sb_q.pop_front();
                if (it.cyc != cyc) begin
                    n_chk++;
                    n_fail++;
                    $display("FAIL %s missed cycle actual=%0d expected=%0d", it.req, cyc, it.cyc);
                end else begin
                    for (int i = 0; i < NREF; i++) check(it.req, i, ref_lost[i], it.exp[i]);
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < NREF; i++) begin
            last_chg[i] = 0;
            seen[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        // R1: flags high during reset
        check("R1", 0, ref_lost[0], 1'b1);
        check("R1", 1, ref_lost[1], 1'b1);
        rst_n = 1'b1;
        cur_req = "R1";
        run(0, 0, 6);
        cur_req = "R2";
        run(3, 0, 30);
        cur_req = "R3";
        set_lvl(0, 1'b1);
        run(0, 0, WIN + 8);
        cur_req = "R6";
        run(2, 0, 12);
        cur_req = "R4";
        set_lvl(0, 1'b0);
        run(0, 0, WIN + 8);
        cur_req = "R5";
        run(WIN, WIN, 5 * WIN);
        cur_req = "R3";
        run(WIN + 1, WIN + 2, 6 * WIN);
        cur_req = "R7";
        run(2, 5, 40);
        run(2, 0, 25);
        run(0, 3, 25);
        cur_req = "R6";
        run(1, 1, 10);
        run(0, 0, 6);
        repeat (6) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule